// File: doc/BRIEF.md
# Use-History Page Replacement Selector

This block chooses which resident page frame gives up its page when a fault needs a free frame. Each frame keeps a use flag and two interval counters. The current idle count grows on every sampling tick in which the frame was not touched. The previous idle count holds the length of the idle stretch that the last use ended. A periodic tick samples every use flag and clears it. A touched frame moves its current count into its previous count and starts again from zero. An untouched frame adds one to its current count.

On a request, the selector compares each eligible frame's current idle stretch with its previous one and applies three tiers in order. The first tier takes a frame that has already stayed idle longer than its previous stretch plus one. The second tier takes the frame whose previous stretch exceeds its current one by the largest margin, among frames idle for at least one tick. The third tier takes the frame with the longest previous stretch. A page-in event loads a frame's previous count from an idle time supplied by the caller and clears its current count. The answer, with the tier that produced it, appears one cycle after the request.

Top module: `rps_victim_sel`

## Requirements
- R1: After reset every frame's use flag and both counts are zero, and `vic_valid_o` is low until a request is made.
- R2: A `touch_v_i` pulse sets the use flag of frame `touch_idx_i`.
- R3: On `tick_i`, a frame whose use flag is set, or which is touched in that same cycle, copies its current count into its previous count and clears its current count. Every use flag is then clear, so a touch that coincides with a tick counts only in that sample.
- R4: On `tick_i`, a frame that was not used adds one to its current count, and the count saturates at 2^CNT_W-1 rather than wrapping.
- R5: A `pgin_v_i` pulse sets the previous count of frame `pgin_idx_i` to `pgin_idle_i`, clears its current count and clears its use flag. It overrides a tick for that frame in the same cycle.
- R6: Tier 1 (code 1): if any eligible frame has a current count greater than its previous count plus one, such a frame is chosen.
- R7: Tier 2 (code 2): otherwise, among eligible frames with a nonzero current count, the frame with the largest previous-minus-current difference is chosen, and that difference may be negative.
- R8: Tier 3 (code 3): otherwise the eligible frame with the largest previous count is chosen.
- R9: Within a tier, ties go to the lowest frame index.
- R10: Only frames with `frame_valid_i` high and `lock_i` low are eligible. With no eligible frame the response carries tier code 0.
- R11: A request sampled at one clock edge gives `vic_valid_o` high for exactly the following cycle. The answer is computed from the history as it stood in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Sampling tick |
| touch_v_i | input | 1 | A frame was referenced |
| touch_idx_i | input | $clog2(NFRAMES) | Referenced frame |
| pgin_v_i | input | 1 | A page was loaded into a frame |
| pgin_idx_i | input | $clog2(NFRAMES) | Frame that received the page |
| pgin_idle_i | input | CNT_W | Idle time of the incoming page since its last use |
| frame_valid_i | input | NFRAMES | Frame holds a page |
| lock_i | input | NFRAMES | Frame is locked out by a transfer |
| req_i | input | 1 | Victim request |
| vic_valid_o | output | 1 | Response valid |
| vic_idx_o | output | $clog2(NFRAMES) | Chosen frame |
| vic_tier_o | output | 2 | Tier that chose it, 0 when no frame is eligible |

## Verification
Two pairs of events can meet in one cycle. A touch can land on the same edge as the sampling tick, and a page-in can arrive on the same edge as a tick for the same frame. The bench drives both coincidences on purpose. It then reads the effect through later victim requests. For the first pair, the touched frame must drop out of tier 1 and must still not count as used at the following tick. For the second pair, the loaded frame must sit in tier 3 with a current count of zero rather than one.

// File: rtl/rps_pkg.sv
package rps_pkg;
   typedef enum logic [1:0] {
      TIER_NONE    = 2'd0,
      TIER_OVERDUE = 2'd1,
      TIER_SHRINK  = 2'd2,
      TIER_LONGEST = 2'd3
   } tier_e;
endpackage

// File: rtl/rps_frame_hist.sv
module rps_frame_hist #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             touch_i,
   input  logic             pgin_i,
   input  logic [CNT_W-1:0] idle_i,
   output logic [CNT_W-1:0] cur_o,
   output logic [CNT_W-1:0] prev_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic use_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         use_q  <= 1'b0;
         cur_o  <= '0;
         prev_o <= '0;
      end else if (pgin_i) begin
         use_q  <= 1'b0;
         cur_o  <= '0;
         prev_o <= idle_i;
      end else if (tick_i) begin
         use_q <= 1'b0;
         if (use_q || touch_i) begin
            prev_o <= cur_o;
            cur_o  <= '0;
         end else if (cur_o != CNT_MAX) begin
            cur_o <= cur_o + 1'b1;
         end
      end else if (touch_i) begin
         use_q <= 1'b1;
      end
   end

   AST_PGIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      pgin_i |=> (cur_o == '0) && (prev_o == $past(idle_i))); // R5
   AST_SAMPLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i && !pgin_i && (use_q || touch_i) |=> (cur_o == '0) && (prev_o == $past(cur_o))); // R3
   AST_USE_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i |=> !use_q); // R3
   AST_TOUCH_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      touch_i && !tick_i && !pgin_i |=> use_q); // R2
   AST_IDLE_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i && !pgin_i && !use_q && !touch_i && (cur_o == CNT_MAX) |=> cur_o == CNT_MAX); // R4
endmodule

// File: rtl/rps_pick.sv
module rps_pick
   import rps_pkg::*;
#(
   parameter int NFRAMES = 8,
   parameter int CNT_W   = 4,
   localparam int IDX_W  = $clog2(NFRAMES)
) (
   input  logic [NFRAMES*CNT_W-1:0] cur_all_i,
   input  logic [NFRAMES*CNT_W-1:0] prev_all_i,
   input  logic [NFRAMES-1:0]       elig_i,
   output logic [IDX_W-1:0]         idx_o,
   output tier_e                    tier_o
);
   localparam int DW = CNT_W + 2;

   logic                 hit1, hit2, hit3;
   logic [IDX_W-1:0]     idx1, idx2, idx3;
   logic signed [DW-1:0] best2, diff;
   logic [CNT_W-1:0]     best3, c, p;

   always_comb begin
      hit1 = 1'b0; hit2 = 1'b0; hit3 = 1'b0;
      idx1 = '0;   idx2 = '0;   idx3 = '0;
      best2 = '0;  best3 = '0;  diff = '0;
      c = '0;      p = '0;
      for (int i = 0; i < NFRAMES; i++) begin
         c    = cur_all_i[i*CNT_W +: CNT_W];
         p    = prev_all_i[i*CNT_W +: CNT_W];
         diff = $signed({2'b00, p}) - $signed({2'b00, c});
         if (elig_i[i]) begin
            if (!hit1 && ({2'b00, c} > ({2'b00, p} + 1'b1))) begin
               hit1 = 1'b1;
               idx1 = IDX_W'(i);
            end
            if ((c != '0) && (!hit2 || (diff > best2))) begin
               hit2  = 1'b1;
               best2 = diff;
               idx2  = IDX_W'(i);
            end
            if (!hit3 || (p > best3)) begin
               hit3  = 1'b1;
               best3 = p;
               idx3  = IDX_W'(i);
            end
         end
      end
      if (hit1) begin
         idx_o = idx1; tier_o = TIER_OVERDUE;
      end else if (hit2) begin
         idx_o = idx2; tier_o = TIER_SHRINK;
      end else if (hit3) begin
         idx_o = idx3; tier_o = TIER_LONGEST;
      end else begin
         idx_o = '0;   tier_o = TIER_NONE;
      end
   end
endmodule

// File: rtl/rps_victim_sel.sv
module rps_victim_sel
   import rps_pkg::*;
#(
   parameter int NFRAMES = 8,
   parameter int CNT_W   = 4,
   localparam int IDX_W  = $clog2(NFRAMES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_i,
   input  logic               touch_v_i,
   input  logic [IDX_W-1:0]   touch_idx_i,
   input  logic               pgin_v_i,
   input  logic [IDX_W-1:0]   pgin_idx_i,
   input  logic [CNT_W-1:0]   pgin_idle_i,
   input  logic [NFRAMES-1:0] frame_valid_i,
   input  logic [NFRAMES-1:0] lock_i,
   input  logic               req_i,
   output logic               vic_valid_o,
   output logic [IDX_W-1:0]   vic_idx_o,
   output logic [1:0]         vic_tier_o
);
   if (NFRAMES < 2) begin : g_bad_frames
      $error("rps_victim_sel: NFRAMES must be at least 2");
   end
   if (CNT_W < 2) begin : g_bad_width
      $error("rps_victim_sel: CNT_W must be at least 2");
   end

   logic [NFRAMES*CNT_W-1:0] cur_all, prev_all;
   logic [NFRAMES-1:0]       elig;
   logic [IDX_W-1:0]         pick_idx;
   tier_e                    pick_tier;

   assign elig = frame_valid_i & ~lock_i;

   for (genvar g = 0; g < NFRAMES; g++) begin : g_frame
      rps_frame_hist #(.CNT_W(CNT_W)) u_hist (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick_i (tick_i),
         .touch_i(touch_v_i && (touch_idx_i == IDX_W'(g))),
         .pgin_i (pgin_v_i && (pgin_idx_i == IDX_W'(g))),
         .idle_i (pgin_idle_i),
         .cur_o  (cur_all[g*CNT_W +: CNT_W]),
         .prev_o (prev_all[g*CNT_W +: CNT_W])
      );
   end

   rps_pick #(.NFRAMES(NFRAMES), .CNT_W(CNT_W)) u_pick (
      .cur_all_i (cur_all),
      .prev_all_i(prev_all),
      .elig_i    (elig),
      .idx_o     (pick_idx),
      .tier_o    (pick_tier)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vic_valid_o <= 1'b0;
         vic_idx_o   <= '0;
         vic_tier_o  <= TIER_NONE;
      end else begin
         vic_valid_o <= req_i;
         if (req_i) begin
            vic_idx_o  <= pick_idx;
            vic_tier_o <= pick_tier;
         end
      end
   end

   AST_PICK_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      vic_valid_o && (vic_tier_o != TIER_NONE) |->
         ((NFRAMES'(1) << vic_idx_o) & $past(elig)) != '0); // R10
   AST_NONE_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      req_i && (elig == '0) |=> vic_valid_o && (vic_tier_o == TIER_NONE)); // R10
   AST_OVERDUE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      vic_valid_o && (vic_tier_o == TIER_OVERDUE) |->
         ({2'b00, CNT_W'($past(cur_all) >> (vic_idx_o*CNT_W))} >
          ({2'b00, CNT_W'($past(prev_all) >> (vic_idx_o*CNT_W))} + 1'b1))); // R6
   AST_SHRINK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      vic_valid_o && (vic_tier_o == TIER_SHRINK) |->
         CNT_W'($past(cur_all) >> (vic_idx_o*CNT_W)) != '0); // R7
endmodule

// File: tb/rps_victim_sel_bench.sv
`timescale 1ns/1ps
module rps_victim_sel_bench;
   localparam int NF = 8;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_i = 1'b0, touch_v_i = 1'b0, pgin_v_i = 1'b0, req_i = 1'b0;
   logic [2:0]    touch_idx_i = '0, pgin_idx_i = '0;
   logic [CW-1:0] pgin_idle_i = '0;
   logic [NF-1:0] frame_valid_i = '1, lock_i = '0;
   logic          vic_valid_o;
   logic [2:0]    vic_idx_o;
   logic [1:0]    vic_tier_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   rps_victim_sel #(.NFRAMES(NF), .CNT_W(CW)) u_rps_victim_sel (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .touch_v_i(touch_v_i), .touch_idx_i(touch_idx_i),
      .pgin_v_i(pgin_v_i), .pgin_idx_i(pgin_idx_i), .pgin_idle_i(pgin_idle_i),
      .frame_valid_i(frame_valid_i), .lock_i(lock_i), .req_i(req_i),
      .vic_valid_o(vic_valid_o), .vic_idx_o(vic_idx_o), .vic_tier_o(vic_tier_o)
   );

   // op: 0 page-in (idx, val = idle), 1 tick (val = frames touched first), 2 request (val = lock mask)
   localparam int NV = 22;
   localparam logic [17:0] VEC [NV] = '{
      {2'd2, 3'd0, 8'h00, 3'd0, 2'd3},   // R1 R9 all zero: tier 3, frame 0
      {2'd0, 3'd0, 8'd2,  3'd0, 2'd0},
      {2'd0, 3'd1, 8'd5,  3'd0, 2'd0},
      {2'd0, 3'd2, 8'd1,  3'd0, 2'd0},
      {2'd0, 3'd3, 8'd7,  3'd0, 2'd0},
      {2'd0, 3'd4, 8'd3,  3'd0, 2'd0},
      {2'd0, 3'd5, 8'd0,  3'd0, 2'd0},
      {2'd0, 3'd6, 8'd6,  3'd0, 2'd0},
      {2'd0, 3'd7, 8'd4,  3'd0, 2'd0},
      {2'd2, 3'd0, 8'h00, 3'd3, 2'd3},   // R8 largest previous count
      {2'd1, 3'd0, 8'h00, 3'd0, 2'd0},
      {2'd2, 3'd0, 8'h00, 3'd3, 2'd2},   // R7 largest difference
      {2'd1, 3'd0, 8'h08, 3'd0, 2'd0},   // R2 touch frame 3
      {2'd2, 3'd0, 8'h00, 3'd5, 2'd1},   // R6 overdue
      {2'd2, 3'd0, 8'h20, 3'd6, 2'd2},   // R10 lock removes frame 5
      {2'd0, 3'd5, 8'd9,  3'd0, 2'd0},
      {2'd2, 3'd0, 8'h00, 3'd6, 2'd2},   // R5 zero current count leaves tier 2
      {2'd1, 3'd0, 8'h40, 3'd0, 2'd0},
      {2'd2, 3'd0, 8'h00, 3'd2, 2'd1},   // R6
      {2'd2, 3'd0, 8'h04, 3'd5, 2'd2},   // R7
      {2'd2, 3'd0, 8'h24, 3'd1, 2'd2},   // R7 R10
      {2'd2, 3'd0, 8'hFF, 3'd0, 2'd0}    // R10 nothing eligible
   };

   task automatic chk(string rq, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; tick_i = 0; touch_v_i = 0; pgin_v_i = 0; req_i = 0;
      lock_i = '0; frame_valid_i = '1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic do_pgin(int idx, int idle);
      @(negedge clk);
      pgin_v_i = 1'b1; pgin_idx_i = 3'(idx); pgin_idle_i = CW'(idle);
      @(negedge clk);
      pgin_v_i = 1'b0;
   endtask

   task automatic do_tick(logic [NF-1:0] mask);
      for (int i = 0; i < NF; i++) begin
         if (mask[i]) begin
            @(negedge clk);
            touch_v_i = 1'b1; touch_idx_i = 3'(i);
            @(negedge clk);
            touch_v_i = 1'b0;
         end
      end
      @(negedge clk);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
   endtask

   task automatic do_req(logic [NF-1:0] lock, int eidx, int etier, string rq);
      @(negedge clk);
      lock_i = lock; req_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0;
      chk({rq, " R11 valid"}, int'(vic_valid_o), 1);
      chk({rq, " tier"}, int'(vic_tier_o), etier);
      if (etier != 0) chk({rq, " frame"}, int'(vic_idx_o), eidx);
      @(negedge clk);
      chk("R11 single-cycle valid", int'(vic_valid_o), 0);
      lock_i = '0;
   endtask

   initial begin
      #(4.0 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      do_reset();
      @(negedge clk);
      chk("R1 no response after reset", int'(vic_valid_o), 0);

      for (int v = 0; v < NV; v++) begin
         case (VEC[v][17:16])
            2'd0: do_pgin(int'(VEC[v][15:13]), int'(VEC[v][12:5]));
            2'd1: do_tick(VEC[v][12:5]);
            default: do_req(VEC[v][12:5], int'(VEC[v][4:2]), int'(VEC[v][1:0]),
                            $sformatf("vector %0d", v));
         endcase
      end

      // R9: equal previous counts, lowest index wins
      do_reset();
      do_pgin(1, 5);
      do_pgin(4, 5);
      do_req('0, 1, 3, "R9 tie");

      // R3: touch on the tick edge counts in that sample only
      do_reset();
      do_tick('0);
      do_tick('0);
      do_req('0, 0, 1, "R6 after two idle ticks");
      @(negedge clk);
      tick_i = 1'b1; touch_v_i = 1'b1; touch_idx_i = 3'd0;
      @(negedge clk);
      tick_i = 1'b0; touch_v_i = 1'b0;
      do_req('0, 1, 1, "R3 coincident touch restarts frame 0");
      frame_valid_i = 8'h01;
      do_tick('0);
      do_req('0, 0, 2, "R3 use flag cleared by the tick");

      // R5: page-in overrides a tick on the same frame
      do_reset();
      frame_valid_i = 8'h01;
      @(negedge clk);
      pgin_v_i = 1'b1; pgin_idx_i = 3'd0; pgin_idle_i = 4'd6; tick_i = 1'b1;
      @(negedge clk);
      pgin_v_i = 1'b0; tick_i = 1'b0;
      do_req('0, 0, 3, "R5 page-in wins over tick");

      // R4: current count saturates (a wrap would leave 2, not above 3)
      do_reset();
      frame_valid_i = 8'h01;
      do_pgin(0, 2);
      for (int k = 0; k < 18; k++) do_tick('0);
      do_req('0, 0, 1, "R4 saturation");

      // R10: no valid frame
      frame_valid_i = '0;
      do_req('0, 0, 0, "R10 no valid frame");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule